// File: doc/BRIEF.md
# Daisy-Chained Readout Chain Controller

This block is one link in a token-passing readout chain. Every link receives an active-low chain enable from the link before it and produces an active-low chain enable for the link after it. Links that take part in the readout hold the token while they shift out a programmed number of words, one per beam-crossing clock. They then pass the token downstream by driving their own outgoing enable low.

A single configuration word sets the behaviour. Its low bits hold the number of words this link contributes. Its top bit selects between two modes. In local mode, a terminal-count comparator produces the outgoing enable. In bypass mode, the incoming enable goes straight through to the outgoing enable. A status vector shows the incoming enable, the outgoing enable and the data-enable flag as separate bits. The configuration word and the running word count can be read back. The controller runs on the beam-crossing clock, which has a 132 ns period. The data serializer and the register bus decoder are outside this block.

Top module: `hsro_chain_ctrl`

## Requirements
- R1: When `cfg_we_i` is high at a clock edge, bits [3:0] of `cfg_wdata_i` become the terminal count and bit 15 becomes the local-mode bit. `cfg_rd_o` returns the local-mode bit in bit 15, the terminal count in bits [3:0], and zeros in all other bits.
- R2: In bypass mode (bit 15 = 0), `chain_en_no` equals `chain_en_ni` in the same cycle, the word count stays 0, and `data_en_o` stays 0.
- R3: While `chain_en_ni` is high at a clock edge, the word count becomes 0 at that edge.
- R4: In local mode, while `chain_en_ni` is low and the count is below the terminal count, the count rises by exactly one at each clock edge. The count is readable on `cur_cnt_o`.
- R5: `data_en_o` is high exactly when the link is in local mode, `chain_en_ni` is low and the count is below the terminal count.
- R6: In local mode, `chain_en_no` goes low once `chain_en_ni` is low and the count equals the terminal count. It stays low until `chain_en_ni` returns high, and it is high in the same cycle that `chain_en_ni` is high.
- R7: `state_o` bit 0 carries `chain_en_ni`, bit 1 carries `chain_en_no` and bit 2 carries `data_en_o`.
- R8: After reset, the link is in bypass mode with a terminal count of 0 and a word count of 0.
- R9: In local mode with a terminal count of 0, `chain_en_no` follows `chain_en_ni` at once and `data_en_o` never rises. This is the illegal setting that software must avoid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beam-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 16 | Configuration word write data |
| chain_en_ni | input | 1 | Incoming chain enable, active low |
| chain_en_no | output | 1 | Outgoing chain enable, active low |
| data_en_o | output | 1 | This link is shifting out words |
| state_o | output | 3 | Chain status bits |
| cfg_rd_o | output | 16 | Configuration word readback |
| cur_cnt_o | output | 4 | Running word count |

## Verification
A counter that skips a step or fails to clear shows up at once on `cur_cnt_o`. The clock edge after the fault also moves the moment `chain_en_no` falls, so the downstream link gets the token one or more words early or late. A wrong mode bit shows up in the same cycle as a mismatch between `chain_en_no` and `chain_en_ni` while the token is being held. A stale comparator shows up as `data_en_o` and `chain_en_no` both being high at the terminal count. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/hsro_pkg.sv
package hsro_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned MODE_B = 15;
  // status bit positions
  localparam int unsigned ST_IN  = 0;
  localparam int unsigned ST_OUT = 1;
  localparam int unsigned ST_DAT = 2;
  localparam int unsigned ST_W   = 3;

  typedef enum logic {
    MODE_BYPASS = 1'b0,
    MODE_LOCAL  = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/hsro_cfg_reg.sv
module hsro_cfg_reg
  import hsro_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_W-1:0]      wdata_i,
  output chain_mode_e           mode_o,
  output logic [CNT_W-1:0]      tc_o,
  output logic [REG_W-1:0]      rd_o
);
  localparam int unsigned PAD_W = MODE_B - CNT_W;

  chain_mode_e      mode_q;
  logic [CNT_W-1:0] tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BYPASS;
      tc_q   <= '0;
    end else if (we_i) begin
      mode_q <= chain_mode_e'(wdata_i[MODE_B]);
      tc_q   <= wdata_i[CNT_W-1:0];
    end
  end

  assign mode_o = mode_q;
  assign tc_o   = tc_q;
  assign rd_o   = {mode_q, {PAD_W{1'b0}}, tc_q};
endmodule

// File: rtl/hsro_word_cnt.sv
module hsro_word_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,   // local mode and token held
  input  logic             clr_i,   // incoming enable released
  input  logic [CNT_W-1:0] tc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             below_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             below;

  assign below = (cnt_q < tc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && below)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign below_o = below;
endmodule

// File: rtl/hsro_chain_sel.sv
module hsro_chain_sel
  import hsro_pkg::*;
(
  input  chain_mode_e mode_i,
  input  logic        en_ni,
  input  logic        below_i,
  output logic        en_no,
  output logic        data_en_o
);
  logic held;
  assign held = ~en_ni;

  always_comb begin
    unique case (mode_i)
      MODE_LOCAL: begin
        data_en_o = held & below_i;
        en_no     = ~(held & ~below_i);
      end
      default: begin
        data_en_o = 1'b0;
        en_no     = en_ni;
      end
    endcase
  end
endmodule

// File: rtl/hsro_chain_ctrl.sv
module hsro_chain_ctrl
  import hsro_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [15:0]      cfg_wdata_i,
  input  logic             chain_en_ni,
  output logic             chain_en_no,
  output logic             data_en_o,
  output logic [2:0]       state_o,
  output logic [15:0]      cfg_rd_o,
  output logic [CNT_W-1:0] cur_cnt_o
);
  chain_mode_e      mode;
  logic [CNT_W-1:0] tc;
  logic             below;
  logic             out_n;
  logic             den;

  hsro_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .mode_o  (mode),
    .tc_o    (tc),
    .rd_o    (cfg_rd_o)
  );

  hsro_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   ((mode == MODE_LOCAL) & ~chain_en_ni),
    .clr_i   (chain_en_ni),
    .tc_i    (tc),
    .cnt_o   (cur_cnt_o),
    .below_o (below)
  );

  hsro_chain_sel u_sel (
    .mode_i    (mode),
    .en_ni     (chain_en_ni),
    .below_i   (below),
    .en_no     (out_n),
    .data_en_o (den)
  );

  assign chain_en_no       = out_n;
  assign data_en_o         = den;
  assign state_o[ST_IN]    = chain_en_ni;
  assign state_o[ST_OUT]   = out_n;
  assign state_o[ST_DAT]   = den;
endmodule

// File: rtl/hsro_chain_chk.sv
module hsro_chain_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             chain_en_ni,
  input logic             chain_en_no,
  input logic             data_en_o,
  input logic [2:0]       state_o,
  input logic [15:0]      cfg_rd_o,
  input logic [CNT_W-1:0] cur_cnt_o
);
  logic loc;
  assign loc = cfg_rd_o[15];

  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc |-> (chain_en_no == chain_en_ni) && !data_en_o);

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_en_ni |=> cur_cnt_o == '0);

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc && !chain_en_ni && data_en_o) |=> cur_cnt_o == $past(cur_cnt_o) + CNT_W'(1));

  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> chain_en_no && !chain_en_ni);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc && !chain_en_no && !cfg_we_i) |=> chain_en_ni || !chain_en_no);

  a_r7_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == {data_en_o, chain_en_no, chain_en_ni});
endmodule

bind hsro_chain_ctrl hsro_chain_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .chain_en_ni (chain_en_ni),
  .chain_en_no (chain_en_no),
  .data_en_o   (data_en_o),
  .state_o     (state_o),
  .cfg_rd_o    (cfg_rd_o),
  .cur_cnt_o   (cur_cnt_o)
);

// File: tb/hsro_chain_ctrl_test.sv
module hsro_chain_ctrl_test;
  localparam int CLK_HALF = 66;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        en_in_n = 1'b1;
  logic        en_out_n, data_en;
  logic [2:0]  state;
  logic [15:0] cfg_rd;
  logic [3:0]  cur_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_tc = 0;
  int m_loc = 0;
  int m_cnt = 0;

  always #CLK_HALF clk = ~clk;

  hsro_chain_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .chain_en_ni(en_in_n), .chain_en_no(en_out_n), .data_en_o(data_en),
    .state_o(state), .cfg_rd_o(cfg_rd), .cur_cnt_o(cur_cnt)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tc = 0; m_loc = 0; m_cnt = 0;
    end else begin
      if (en_in_n) m_cnt = 0;
      else if (m_loc == 1 && m_cnt < m_tc) m_cnt = m_cnt + 1;
      if (cfg_we) begin
        m_tc  = int'(cfg_wdata[3:0]);
        m_loc = int'(cfg_wdata[15]);
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int e_den, e_out, e_rd;
      e_den = (m_loc == 1 && !en_in_n && m_cnt < m_tc) ? 1 : 0;
      if (m_loc == 0) e_out = int'(en_in_n);
      else e_out = (!en_in_n && m_cnt >= m_tc) ? 0 : 1;
      e_rd = m_loc * 32768 + m_tc;
      chk("R1 cfg readback", int'(cfg_rd), e_rd);
      chk("R3/R4 word count", int'(cur_cnt), m_cnt);
      chk("R5 data enable", int'(data_en), e_den);
      chk(m_loc == 1 ? "R6 outgoing enable" : "R2 bypass enable", int'(en_out_n), e_out);
      chk("R7 state bits", int'(state), e_den * 4 + e_out * 2 + int'(en_in_n));
    end
  end

  task automatic wr(int loc, int tc);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 16'((loc << 15) | (tc & 15) | 16'h0550);
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic hold(int cycles);
    @(negedge clk);
    en_in_n = 1'b0;
    repeat (cycles) @(negedge clk);
    en_in_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_HALF * 3);
    // R8: reset state
    chk("R8 reset cfg", int'(cfg_rd), 0);
    chk("R8 reset count", int'(cur_cnt), 0);
    chk("R8 reset out", int'(en_out_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: bypass follows input, no counting
    hold(6);
    // R1, R4, R6: local with five words
    wr(1, 5);
    hold(10);
    // R6: early release at count 2
    hold(2);
    wr(1, 1);
    hold(4);
    wr(1, 15);
    hold(20);
    // R9: illegal zero terminal count
    wr(1, 0);
    hold(3);
    @(negedge clk); #2;
    chk("R9 zero tc out", int'(en_out_n), 1);
    // switch to bypass mid-hold
    wr(1, 6);
    @(negedge clk); en_in_n = 1'b0;
    repeat (3) @(negedge clk);
    wr(0, 6);
    repeat (3) @(negedge clk);
    en_in_n = 1'b1;
    repeat (2) @(negedge clk);
    // pseudo-random toggling across modes
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      en_in_n = ($urandom % 5) == 0;
      if (($urandom % 40) == 0) begin
        cfg_we = 1'b1;
        cfg_wdata = 16'($urandom);
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule